// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block generates the core reset of a device. It holds the device in reset after a power-on event or an accepted brown-out. It then releases reset through a chain of timed delays. The first delay is a power-up timer that counts ticks of a slow RC time base. The second is an oscillator settling counter that counts oscillator-cycle ticks, and it runs only when the clock source is a crystal or resonator. Every supply condition arrives as a digital flag: a power-on pulse, and one "supply above trip level" flag for each of the selectable brown-out levels. All delay lengths are parameters.

The sequencer has five states:
- `ST_POR_HOLD` is forced asynchronously by the power-on pulse.
- `ST_BOR_HOLD` is entered after a filtered brown-out.
- `ST_PWRT_RUN` runs the power-up timer.
- `ST_OST_RUN` runs the oscillator settling count.
- `ST_RUN` is normal operation, and the only state with reset released.

The transitions are:
- POR_HOLD to PWRT_RUN when the timer is enabled. Otherwise POR_HOLD goes to OST_RUN in crystal modes, or to RUN.
- BOR_HOLD to PWRT_RUN when the selected flag returns high.
- PWRT_RUN to OST_RUN in crystal modes, or to RUN, on timer expiry.
- OST_RUN to RUN on count expiry.
- RUN to OST_RUN on a wake request in crystal modes.
- PWRT_RUN, OST_RUN or RUN to BOR_HOLD on a filtered brown-out.

Two latched cause flags record power-on and brown-out. Software clears each one by pulsing the matching bit of a write-one-to-clear strobe.

Top module: `pwrup_rst_seq`

## Requirements
- R1: A high `por_pulse` asynchronously forces `ST_POR_HOLD`, sets `rst_out` and `cause_por`, and clears `cause_bor`. This event overrides every other input.
- R2: With `cfg_pwrt_en`=1, the first clock edge after `por_pulse` falls enters `ST_PWRT_RUN`. The timer then consumes exactly PWRT_TICKS edges that have `rc_tick`=1 before it moves on, and `rst_out` stays high meanwhile.
- R3: With `cfg_pwrt_en`=0, the power-up timer is skipped after power-on.
- R4: The oscillator settling count consumes exactly OST_TICKS (default 1024) edges with `osc_tick`=1. It runs only when `cfg_osc_mode` is 0, 1 or 2 (the low-power, medium and high-speed crystal modes). Modes 3 to 7 skip it.
- R5: A brown-out is accepted only when the selected flag is sampled low on more than BOR_MIN consecutive edges. A dip of BOR_MIN edges or fewer causes no reset.
- R6: The selected flag is `bor_above[cfg_trip_sel]`. Flags of the other levels are ignored.
- R7: With `cfg_bor_en`=0, no brown-out is accepted and `cause_bor` stays 0.
- R8: In `ST_BOR_HOLD`, `rst_out` stays high while the selected flag is low. When the flag returns high, the power-up timer always runs, whatever the value of `cfg_pwrt_en`.
- R9: A brown-out accepted during `ST_PWRT_RUN` returns to `ST_BOR_HOLD`. The timer is reloaded, so a full PWRT_TICKS runs after recovery.
- R10: A `wake_req` in `ST_RUN` enters `ST_OST_RUN` in crystal modes, without the power-up timer. In other modes it has no effect.
- R11: Entering `ST_BOR_HOLD` sets `cause_bor`. Bit 0 of `cause_clr` clears `cause_por`, and bit 1 clears `cause_bor`. A set takes priority over a clear.
- R12: `rst_out` is a register that is 0 exactly while the state is `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| bor_above | input | N_TRIP | Per-level flag, 1 = supply above that trip level |
| cfg_bor_en | input | 1 | Brown-out detection enable |
| cfg_pwrt_en | input | 1 | Power-up timer enable for power-on only |
| cfg_trip_sel | input | $clog2(N_TRIP) | Trip level select |
| cfg_osc_mode | input | 3 | Oscillator mode, 0 to 2 are crystal modes |
| wake_req | input | 1 | Wake-from-sleep request |
| rc_tick | input | 1 | Slow RC time-base tick enable |
| osc_tick | input | 1 | Oscillator-cycle tick enable |
| cause_clr | input | 2 | Write-one-to-clear strobe for the cause flags |
| rst_out | output | 1 | Registered reset, active high |
| cause_por | output | 1 | Latched power-on cause |
| cause_bor | output | 1 | Latched brown-out cause |

## Verification
The assertions check on every cycle that:
- reset is released only in the run state;
- each entry into the timer state starts from a full load;
- a brown-out hold is never entered with detection disabled;
- the hold state is left only on a high selected flag;
- the settling count runs only in crystal modes;
- the brown-out cause is set on hold entry.

Only the bench scenarios can show the exact release latency for each mode combination. They also cover the boundary between a tolerated dip and an accepted brown-out, the full timer restart after a recurring brown-out, wake behaviour per mode, and that unselected trip levels are ignored.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
    localparam int OSC_W = 3;

    typedef enum logic [2:0] {
        ST_POR_HOLD,
        ST_BOR_HOLD,
        ST_PWRT_RUN,
        ST_OST_RUN,
        ST_RUN
    } seq_state_e;

    // Modes 0..2 are crystal or resonator sources that need a settling count
    function automatic logic is_xtal(input logic [OSC_W-1:0] mode);
        return (mode <= OSC_W'(2));
    endfunction
endpackage

// File: rtl/pwrup_delay_cnt.sv
module pwrup_delay_cnt #(
    parameter int LEN = 16
) (
    input  logic                       clk,
    input  logic                       clr,
    input  logic                       load,
    input  logic                       tick,
    output logic [$clog2(LEN+1)-1:0]   cnt_o,
    output logic                       expire
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            cnt <= '0;
        else if (load)
            cnt <= CW'(LEN);
        else if (tick && cnt != '0)
            cnt <= cnt - CW'(1);
    end

    // Expires on the edge that consumes the last tick
    assign expire = tick && (cnt == CW'(1));
    assign cnt_o  = cnt;
endmodule

// File: rtl/pwrup_bor_filter.sv
module pwrup_bor_filter #(
    parameter int N_TRIP  = 4,
    parameter int BOR_MIN = 8
) (
    input  logic                        clk,
    input  logic                        clr,
    input  logic                        enable,
    input  logic [N_TRIP-1:0]           flags,
    input  logic [$clog2(N_TRIP)-1:0]   sel,
    output logic                        sel_flag,
    output logic                        trip
);
    localparam int FW = $clog2(BOR_MIN + 1);

    logic [FW-1:0] low_cnt;
    logic          low_now;

    assign sel_flag = flags[sel];
    assign low_now  = enable && !sel_flag;

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            low_cnt <= '0;
        else if (!low_now)
            low_cnt <= '0;
        else if (low_cnt != FW'(BOR_MIN))
            low_cnt <= low_cnt + FW'(1);
    end

    // Current sample is the (BOR_MIN+1)th consecutive low one
    assign trip = low_now && (low_cnt == FW'(BOR_MIN));
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
    import pwrup_pkg::*;
#(
    parameter int PWRT_TICKS = 16,
    parameter int OST_TICKS  = 1024,
    parameter int BOR_MIN    = 8,
    parameter int N_TRIP     = 4
) (
    input  logic                        clk,
    input  logic                        por_pulse,
    input  logic [N_TRIP-1:0]           bor_above,
    input  logic                        cfg_bor_en,
    input  logic                        cfg_pwrt_en,
    input  logic [$clog2(N_TRIP)-1:0]   cfg_trip_sel,
    input  logic [OSC_W-1:0]            cfg_osc_mode,
    input  logic                        wake_req,
    input  logic                        rc_tick,
    input  logic                        osc_tick,
    input  logic [1:0]                  cause_clr,
    output logic                        rst_out,
    output logic                        cause_por,
    output logic                        cause_bor
);
    localparam int PW = $clog2(PWRT_TICKS + 1);
    localparam int OW = $clog2(OST_TICKS + 1);

    seq_state_e    state, nx;
    logic          sel_flag, bor_trip, xtal;
    logic          pwrt_load, pwrt_exp, ost_load, ost_exp;
    logic [PW-1:0] pwrt_cnt;
    logic [OW-1:0] ost_cnt;

    assign xtal = is_xtal(cfg_osc_mode);

    pwrup_bor_filter #(.N_TRIP(N_TRIP), .BOR_MIN(BOR_MIN)) u_filt (
        .clk      (clk),
        .clr      (por_pulse),
        .enable   (cfg_bor_en),
        .flags    (bor_above),
        .sel      (cfg_trip_sel),
        .sel_flag (sel_flag),
        .trip     (bor_trip)
    );

    pwrup_delay_cnt #(.LEN(PWRT_TICKS)) u_pwrt (
        .clk    (clk),
        .clr    (por_pulse),
        .load   (pwrt_load),
        .tick   (rc_tick),
        .cnt_o  (pwrt_cnt),
        .expire (pwrt_exp)
    );

    pwrup_delay_cnt #(.LEN(OST_TICKS)) u_ost (
        .clk    (clk),
        .clr    (por_pulse),
        .load   (ost_load),
        .tick   (osc_tick),
        .cnt_o  (ost_cnt),
        .expire (ost_exp)
    );

    always_comb begin
        nx = state;
        unique case (state)
            ST_POR_HOLD: begin
                if (cfg_pwrt_en) nx = ST_PWRT_RUN;
                else if (xtal)   nx = ST_OST_RUN;
                else             nx = ST_RUN;
            end
            ST_BOR_HOLD: begin
                if (sel_flag) nx = ST_PWRT_RUN;
            end
            ST_PWRT_RUN: begin
                if (bor_trip)      nx = ST_BOR_HOLD;
                else if (pwrt_exp) nx = xtal ? ST_OST_RUN : ST_RUN;
            end
            ST_OST_RUN: begin
                if (bor_trip)     nx = ST_BOR_HOLD;
                else if (ost_exp) nx = ST_RUN;
            end
            ST_RUN: begin
                if (bor_trip)             nx = ST_BOR_HOLD;
                else if (wake_req && xtal) nx = ST_OST_RUN;
            end
            default: nx = ST_POR_HOLD;
        endcase
    end

    assign pwrt_load = (nx == ST_PWRT_RUN) && (state != ST_PWRT_RUN);
    assign ost_load  = (nx == ST_OST_RUN)  && (state != ST_OST_RUN);

    // State register
    always_ff @(posedge clk or posedge por_pulse) begin
        if (por_pulse) state <= ST_POR_HOLD;
        else           state <= nx;
    end

    // Output registers
    always_ff @(posedge clk or posedge por_pulse) begin
        if (por_pulse) begin
            rst_out   <= 1'b1;
            cause_por <= 1'b1;
            cause_bor <= 1'b0;
        end else begin
            rst_out <= (nx != ST_RUN);
            if (cause_clr[0]) cause_por <= 1'b0;
            if (nx == ST_BOR_HOLD && state != ST_BOR_HOLD)
                cause_bor <= 1'b1;
            else if (cause_clr[1])
                cause_bor <= 1'b0;
        end
    end

    logic unused_ok;
    assign unused_ok = ^ost_cnt;
endmodule

// File: rtl/pwrup_rst_seq_chk.sv
module pwrup_rst_seq_chk
    import pwrup_pkg::*;
#(
    parameter int PWRT_TICKS = 16
) (
    input logic                              clk,
    input logic                              por_pulse,
    input logic                              cfg_bor_en,
    input logic [OSC_W-1:0]                  cfg_osc_mode,
    input seq_state_e                        state,
    input logic                              sel_flag,
    input logic                              rst_out,
    input logic                              cause_bor,
    input logic [$clog2(PWRT_TICKS+1)-1:0]   pwrt_cnt
);
    p_run_releases_r12: assert property (@(posedge clk) disable iff (por_pulse)
        (state == ST_RUN) |-> !rst_out);

    p_reset_outside_run_r12: assert property (@(posedge clk) disable iff (por_pulse)
        (state != ST_RUN) |-> rst_out);

    p_pwrt_full_load_r9: assert property (@(posedge clk) disable iff (por_pulse)
        $rose(state == ST_PWRT_RUN) |-> (pwrt_cnt == ($clog2(PWRT_TICKS+1))'(PWRT_TICKS)));

    p_bor_needs_enable_r7: assert property (@(posedge clk) disable iff (por_pulse)
        $rose(state == ST_BOR_HOLD) |-> $past(cfg_bor_en));

    p_bor_hold_waits_r8: assert property (@(posedge clk) disable iff (por_pulse)
        (state == ST_BOR_HOLD && !sel_flag) |=> (state == ST_BOR_HOLD));

    p_ost_xtal_only_r4: assert property (@(posedge clk) disable iff (por_pulse)
        (state == ST_OST_RUN) |-> is_xtal(cfg_osc_mode));

    p_bor_cause_set_r11: assert property (@(posedge clk) disable iff (por_pulse)
        $rose(state == ST_BOR_HOLD) |-> cause_bor);
endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk #(.PWRT_TICKS(PWRT_TICKS)) u_chk (
    .clk          (clk),
    .por_pulse    (por_pulse),
    .cfg_bor_en   (cfg_bor_en),
    .cfg_osc_mode (cfg_osc_mode),
    .state        (state),
    .sel_flag     (sel_flag),
    .rst_out      (rst_out),
    .cause_bor    (cause_bor),
    .pwrt_cnt     (pwrt_cnt)
);

// File: tb/sim_pwrup_rst_seq.sv
module sim_pwrup_rst_seq;
    localparam int CLK_P = 10;
    localparam int PWRT  = 16;
    localparam int OST   = 1024;
    localparam int BMIN  = 8;

    logic       clk = 1'b0;
    logic       por_pulse = 1'b1;
    logic [3:0] bor_above = 4'hF;
    logic       cfg_bor_en = 1'b0, cfg_pwrt_en = 1'b1;
    logic [1:0] cfg_trip_sel = 2'd0;
    logic [2:0] cfg_osc_mode = 3'd4;
    logic       wake_req = 1'b0, rc_tick = 1'b1, osc_tick = 1'b1;
    logic [1:0] cause_clr = 2'b00;
    logic       rst_out, cause_por, cause_bor;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    pwrup_rst_seq #(.PWRT_TICKS(PWRT), .OST_TICKS(OST), .BOR_MIN(BMIN), .N_TRIP(4)) u0 (
        .clk(clk), .por_pulse(por_pulse), .bor_above(bor_above),
        .cfg_bor_en(cfg_bor_en), .cfg_pwrt_en(cfg_pwrt_en),
        .cfg_trip_sel(cfg_trip_sel), .cfg_osc_mode(cfg_osc_mode),
        .wake_req(wake_req), .rc_tick(rc_tick), .osc_tick(osc_tick),
        .cause_clr(cause_clr), .rst_out(rst_out),
        .cause_por(cause_por), .cause_bor(cause_bor)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Edges until rst_out reads low, sampled at falling edges
    task automatic count_release(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            n++;
            if (!rst_out) break;
        end
    endtask

    task automatic power_on();
        @(negedge clk);
        por_pulse = 1'b1;
        #1;
        check("R1 rst_out on power-on", rst_out, 1);
        repeat (2) @(negedge clk);
        check("R1 cause_por set", cause_por, 1);
        check("R1 cause_bor cleared", cause_bor, 0);
        por_pulse = 1'b0;
    endtask

    typedef struct packed {
        logic       pwrt;
        logic [2:0] mode;
        int         exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 3'd4, 1 + PWRT},
        '{1'b0, 3'd5, 1},
        '{1'b1, 3'd1, 1 + PWRT + OST},
        '{1'b0, 3'd0, 1 + OST},
        '{1'b0, 3'd2, 1 + OST},
        '{1'b1, 3'd7, 1 + PWRT}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 reset state rst_out", rst_out, 1);
        check("R12 held in reset while pulse high", rst_out, 1);

        // R2 R3 R4: release latency per configuration
        foreach (VECS[i]) begin
            cfg_pwrt_en  = VECS[i].pwrt;
            cfg_osc_mode = VECS[i].mode;
            power_on();
            count_release(n);
            check($sformatf("R2 R3 R4 release latency row %0d", i), n, VECS[i].exp);
        end

        // R11 clear of power-on cause
        @(negedge clk); cause_clr = 2'b01;
        @(negedge clk); cause_clr = 2'b00;
        check("R11 cause_por cleared", cause_por, 0);

        // R7: detection disabled, long dip ignored
        cfg_osc_mode = 3'd4; cfg_bor_en = 1'b0; cfg_trip_sel = 2'd0;
        bor_above[0] = 1'b0;
        repeat (30) @(negedge clk);
        check("R7 no reset when disabled", rst_out, 0);
        check("R7 cause_bor stays 0", cause_bor, 0);
        bor_above[0] = 1'b1;

        // R5: dip of exactly BMIN edges tolerated
        cfg_bor_en = 1'b1;
        @(negedge clk);
        bor_above[0] = 1'b0;
        repeat (BMIN) @(negedge clk);
        bor_above[0] = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 short dip ignored", rst_out, 0);

        // R6: unselected level ignored, selected level trips
        cfg_trip_sel = 2'd2;
        bor_above[1] = 1'b0;
        repeat (30) @(negedge clk);
        check("R6 unselected flag ignored", rst_out, 0);
        bor_above[1] = 1'b1;
        bor_above[2] = 1'b0;
        repeat (BMIN + 1) @(negedge clk);
        check("R5 dip of BMIN+1 edges resets", rst_out, 1);
        check("R11 cause_bor set", cause_bor, 1);

        // R8: hold while low, then timer runs with cfg_pwrt_en=0
        cfg_pwrt_en = 1'b0;
        repeat (40) @(negedge clk);
        check("R8 held while supply low", rst_out, 1);
        bor_above[2] = 1'b1;
        count_release(n);
        check("R8 timer runs after brown-out", n, 1 + PWRT);

        // R9: recurring brown-out during the timer reloads it
        bor_above[2] = 1'b0;
        repeat (BMIN + 1) @(negedge clk);
        bor_above[2] = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 in timer", rst_out, 1);
        bor_above[2] = 1'b0;
        repeat (BMIN + 1) @(negedge clk);
        bor_above[2] = 1'b1;
        count_release(n);
        check("R9 full timer after recurrence", n, 1 + PWRT);

        // R11 clear of brown-out cause
        @(negedge clk); cause_clr = 2'b10;
        @(negedge clk); cause_clr = 2'b00;
        check("R11 cause_bor cleared", cause_bor, 0);

        // R10: wake in non-crystal mode has no effect
        wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 wake ignored non-crystal", rst_out, 0);

        // R10: wake in crystal mode runs settling count only
        cfg_osc_mode = 3'd1;
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        check("R10 wake asserts reset", rst_out, 1);
        count_release(n);
        check("R10 wake settling latency", n + 1, 1 + OST);

        // R1: power-on overrides a brown-out in progress
        bor_above[2] = 1'b0;
        repeat (BMIN + 1) @(negedge clk);
        check("R11 cause_bor set again", cause_bor, 1);
        bor_above[2] = 1'b1;
        cfg_pwrt_en = 1'b1;
        power_on();
        check("R1 por_pulse deasserted", por_pulse, 0);

        finish_run();
    end
endmodule